// File: doc/BRIEF.md
# Timed Four-Rail Power Sequencer

This controller brings four supply rails up and down in an order set by per-channel delay values. Each rail is switched by a gate-enable output. A filtered rail-good level comes in for each rail. An enable input, whose active level is set by a parameter, requests power-up and power-down. A ramp-complete flag comes back from each channel once its gate has fully ramped. All time is counted in millisecond ticks taken from a prescaled core clock.

To turn on, the rails and the enable must hold valid for a qualification window. All on-delay timers then start together, and each gate switches on when its own delay expires. When every gate is on and has reported ramp complete, a settling window runs. At its end the reset-done output is released.

Deasserting the enable pulls reset-done low. All off-delay timers then start together, and each gate drops when its own delay expires. A rail dropping out while a sequence is active is a fault. On a fault, every gate is cut at once and the shared system-reset line is pulled low. The system-reset line is an open-drain wire shared by several controllers. It is modelled here as a drive-low output and a sense input. Pulling the line low kills all gates. A rising edge on the line starts turn-on without the qualification window.

Top module: `rail_sequencer`

## Requirements
- R1: A change on a rail-good input or on the active-level enable takes effect only after it has held for FILT_CYC consecutive clock cycles. A shorter excursion has no effect on the gates, on reset-done or on system-reset drive.
- R2: With the system-reset line high, turn-on starts QUAL_MS ticks after all rails and the enable become valid (filtered). One tick is TICK_DIV clock cycles.
- R3: At the start of turn-on, every channel's on timer starts from zero. Channel i (on delay in bits [8i+7:8i] of onDelay) raises its gate on tick number d_i+1. A delay of 0 acts on the first tick. No gate rises while reset-done is high or system reset is being driven.
- R4: Once all gates are on and all ramp-complete flags are high, the transition to settling occurs on the next clock edge. Reset-done rises SETTLE_MS ticks after that edge. Reset-done high implies all gates on.
- R5: A filtered rail loss during turn-on, settling, running or turn-off clears all gates on the same edge on which system-reset drive rises and reset-done is low.
- R6: Deasserting the enable with no fault drops reset-done first, with all gates unchanged on that edge. All off timers then start from zero, and channel i (bits [8i+7:8i] of offDelay) clears its gate on tick number off_i+1.
- R7: The system-reset sense input being low clears every gate on the next clock edge, whatever the state.
- R8: In idle, a rising edge on the system-reset sense input, with rails and enable valid, starts turn-on on that edge. A rising edge caused by this block's own release of the line is ignored.
- R9: Parameter EN_ACTIVE_HIGH=1 makes enIn active high. A value of 0 makes it active low.
- R10: After a fault clears, the block returns to idle and turns on again only after the full QUAL_MS qualification window.
- R11: System-reset drive stays asserted as long as the filtered rail fault persists.
- R12: After reset, all gates are off, reset-done is low and system reset is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| railGood | input | NCH | Rail-good comparator levels, one per channel |
| enIn | input | 1 | Sequence enable, polarity set by EN_ACTIVE_HIGH |
| sysRstIn | input | 1 | Sensed level of the shared system-reset line |
| sysRstDrv | output | 1 | 1 pulls the shared system-reset line low |
| rampDone | input | NCH | Gate-ramp-complete flags, one per channel |
| onDelay | input | NCH*DW | Per-channel on delays in ticks, channel i at bits [DW*i+DW-1:DW*i] |
| offDelay | input | NCH*DW | Per-channel off delays in ticks, same packing |
| gateEn | output | NCH | Gate-enable outputs |
| resetDone | output | 1 | 1 releases the open-drain reset-done line high |

## Verification
The subtle collision is between recovering from a fault and the fast-start path. When the block releases the shared line, the line rises in the same cycle the block returns to idle. That edge must not count as a fast start. The bench provokes this with two instances on one wired-AND line, opposite enable polarities, and shared rails. It drops a rail past the filter, then restores it. The judgement is that the gates stay off one cycle before the full qualification window expires and all rise on the exact cycle computed from the tick period. A second overlap is enable removal in a cycle where a tick is due. This is judged by reset-done falling while every gate keeps its value.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ON     = 3'd1,
    ST_SETTLE = 3'd2,
    ST_RUN    = 3'd3,
    ST_OFF    = 3'd4,
    ST_FAULT  = 3'd5
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrTime;   // zero prescaler and elapsed-tick counter
    logic onPhase;   // gates may switch on at expiry
    logic offPhase;  // gates may switch off at expiry
    logic killAll;   // clear every gate on this edge
  } seqStrobe_t;

endpackage

// File: rtl/seq_dpath.sv
module seq_dpath
  import seq_pkg::*;
#(
  parameter int NCH            = 4,
  parameter int DW             = 8,
  parameter int CW             = 9,
  parameter int TICK_DIV       = 100000,
  parameter int FILT_CYC       = 3000,
  parameter bit EN_ACTIVE_HIGH = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NCH-1:0]    railGood,
  input  logic              enIn,
  input  logic [NCH*DW-1:0] onDelay,
  input  logic [NCH*DW-1:0] offDelay,
  input  seqStrobe_t        strobe,
  output logic              railsOk,
  output logic              enOk,
  output logic              tick,
  output logic [CW-1:0]     msCnt,
  output logic [NCH-1:0]    gateEn
);

  localparam int PW = $clog2(TICK_DIV);
  localparam int FW = $clog2(FILT_CYC + 1);
  localparam int NF = NCH + 1;

  logic [NF-1:0] rawVec;
  logic [NF-1:0] fltVec;
  logic          enAct;

  assign enAct  = EN_ACTIVE_HIGH ? enIn : ~enIn;
  assign rawVec = {enAct, railGood};

  // symmetric persistence filter on every qualified input
  for (genvar f = 0; f < NF; f++) begin : g_filt
    logic [FW-1:0] runLen;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        runLen    <= '0;
        fltVec[f] <= 1'b0;
      end else if (rawVec[f] != fltVec[f]) begin
        if (runLen == FW'(FILT_CYC - 1)) begin
          fltVec[f] <= rawVec[f];
          runLen    <= '0;
        end else begin
          runLen <= runLen + 1'b1;
        end
      end else begin
        runLen <= '0;
      end
    end
  end

  assign railsOk = &fltVec[NCH-1:0];
  assign enOk    = fltVec[NCH];

  // millisecond prescaler, realigned at each phase start
  logic [PW-1:0] preCnt;
  assign tick = (preCnt == PW'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        preCnt <= '0;
    else if (strobe.clrTime || tick)  preCnt <= '0;
    else                              preCnt <= preCnt + 1'b1;
  end

  // shared elapsed-tick counter, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         msCnt <= '0;
    else if (strobe.clrTime)           msCnt <= '0;
    else if (tick && (msCnt != '1))    msCnt <= msCnt + 1'b1;
  end

  // per-channel gate latches fired by delay expiry
  for (genvar c = 0; c < NCH; c++) begin : g_gate
    logic [DW-1:0] dOn;
    logic [DW-1:0] dOff;
    assign dOn  = onDelay[c*DW +: DW];
    assign dOff = offDelay[c*DW +: DW];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                               gateEn[c] <= 1'b0;
      else if (strobe.killAll)                                 gateEn[c] <= 1'b0;
      else if (strobe.onPhase && tick && (msCnt >= CW'(dOn)))  gateEn[c] <= 1'b1;
      else if (strobe.offPhase && tick && (msCnt >= CW'(dOff))) gateEn[c] <= 1'b0;
    end
  end

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int CW        = 9,
  parameter int QUAL_MS   = 10,
  parameter int SETTLE_MS = 160
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           railsOk,
  input  logic           enOk,
  input  logic           tick,
  input  logic [CW-1:0]  msCnt,
  input  logic [NCH-1:0] gateEn,
  input  logic [NCH-1:0] rampDone,
  input  logic           sysRstIn,
  output seqStrobe_t     strobe,
  output logic           resetDone,
  output logic           sysRstDrv
);

  seqState_t state, nextState;
  logic      sysPrev, drvPrev;
  logic      ready, allUp, riseIn, active;

  assign ready  = railsOk && enOk;
  assign allUp  = (&gateEn) && (&rampDone);
  assign riseIn = sysRstIn && !sysPrev && !drvPrev;
  assign active = (state == ST_ON) || (state == ST_SETTLE) ||
                  (state == ST_RUN) || (state == ST_OFF);

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:   if (sysRstIn && ready &&
                     (riseIn || (tick && msCnt == CW'(QUAL_MS - 1))))
                   nextState = ST_ON;
      ST_ON:     if (!enOk)      nextState = ST_OFF;
                 else if (allUp) nextState = ST_SETTLE;
      ST_SETTLE: if (!enOk)      nextState = ST_OFF;
                 else if (tick && msCnt == CW'(SETTLE_MS - 1))
                                 nextState = ST_RUN;
      ST_RUN:    if (!enOk)      nextState = ST_OFF;
      ST_OFF:    if (gateEn == '0) nextState = ST_IDLE;
      ST_FAULT:  if (railsOk)    nextState = ST_IDLE;
      default:                   nextState = ST_IDLE;
    endcase
    if (!sysRstIn && state != ST_FAULT) nextState = ST_IDLE;
    if (active && !railsOk)             nextState = ST_FAULT;
  end

  always_comb begin
    strobe.clrTime  = (nextState != state) ||
                      ((state == ST_IDLE) && !(ready && sysRstIn));
    strobe.onPhase  = (state == ST_ON);
    strobe.offPhase = (state == ST_OFF);
    strobe.killAll  = (nextState == ST_FAULT) || !sysRstIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      sysPrev <= 1'b1;
      drvPrev <= 1'b0;
    end else begin
      state   <= nextState;
      sysPrev <= sysRstIn;
      drvPrev <= (state == ST_FAULT);
    end
  end

  assign resetDone = (state == ST_RUN);
  assign sysRstDrv = (state == ST_FAULT);

endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
  import seq_pkg::*;
#(
  parameter int NCH            = 4,
  parameter int DW             = 8,
  parameter int TICK_DIV       = 100000,
  parameter int FILT_CYC       = 3000,
  parameter int QUAL_MS        = 10,
  parameter int SETTLE_MS      = 160,
  parameter bit EN_ACTIVE_HIGH = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NCH-1:0]    railGood,
  input  logic              enIn,
  input  logic              sysRstIn,
  output logic              sysRstDrv,
  input  logic [NCH-1:0]    rampDone,
  input  logic [NCH*DW-1:0] onDelay,
  input  logic [NCH*DW-1:0] offDelay,
  output logic [NCH-1:0]    gateEn,
  output logic              resetDone
);

  localparam int SPAN1 = ((2 ** DW) > SETTLE_MS) ? (2 ** DW) : SETTLE_MS;
  localparam int SPAN2 = (SPAN1 > QUAL_MS) ? SPAN1 : QUAL_MS;
  localparam int CW    = $clog2(SPAN2 + 1);

  seqStrobe_t    strobe;
  logic          railsOk, enOk, tick;
  logic [CW-1:0] msCnt;

  seq_dpath #(
    .NCH(NCH), .DW(DW), .CW(CW), .TICK_DIV(TICK_DIV),
    .FILT_CYC(FILT_CYC), .EN_ACTIVE_HIGH(EN_ACTIVE_HIGH)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .railGood(railGood), .enIn(enIn),
    .onDelay(onDelay), .offDelay(offDelay), .strobe(strobe),
    .railsOk(railsOk), .enOk(enOk), .tick(tick), .msCnt(msCnt),
    .gateEn(gateEn)
  );

  seq_ctrl #(
    .NCH(NCH), .CW(CW), .QUAL_MS(QUAL_MS), .SETTLE_MS(SETTLE_MS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .railsOk(railsOk), .enOk(enOk), .tick(tick),
    .msCnt(msCnt), .gateEn(gateEn), .rampDone(rampDone),
    .sysRstIn(sysRstIn), .strobe(strobe), .resetDone(resetDone),
    .sysRstDrv(sysRstDrv)
  );

endmodule

// File: rtl/seq_chk.sv
module seq_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rstN,
  input logic           sysRstIn,
  input logic           sysRstDrv,
  input logic [NCH-1:0] gateEn,
  input logic           resetDone
);

  assert_line_kill_R7: assert property (@(posedge clk) disable iff (!rstN)
    !sysRstIn |=> (gateEn == '0));

  assert_fault_cut_R5: assert property (@(posedge clk) disable iff (!rstN)
    sysRstDrv |-> ((gateEn == '0) && !resetDone));

  assert_done_gates_R4: assert property (@(posedge clk) disable iff (!rstN)
    resetDone |-> (&gateEn));

  assert_done_first_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(resetDone) && !sysRstDrv && $past(sysRstIn)) |-> (gateEn == $past(gateEn)));

  assert_rise_clean_R3: assert property (@(posedge clk) disable iff (!rstN)
    (|(gateEn & ~$past(gateEn))) |-> (!resetDone && !sysRstDrv));

endmodule

bind rail_sequencer seq_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rstN(rstN), .sysRstIn(sysRstIn), .sysRstDrv(sysRstDrv),
  .gateEn(gateEn), .resetDone(resetDone)
);

// File: tb/sim_rail_sequencer.sv
module sim_rail_sequencer;

  localparam int NCH    = 4;
  localparam int DW     = 8;
  localparam int DIV    = 4;
  localparam int FILT   = 3;
  localparam int QUAL   = 10;
  localparam int SETTLE = 160;
  localparam logic [NCH-1:0] ALL = '1;

  // {on3,on2,on1,on0, off3,off2,off1,off0}
  localparam logic [63:0] VEC [6] = '{
    {8'd3,  8'd2,  8'd1,  8'd0,  8'd0, 8'd1, 8'd2, 8'd3},
    {8'd0,  8'd1,  8'd2,  8'd3,  8'd3, 8'd2, 8'd1, 8'd0},
    {8'd5,  8'd5,  8'd5,  8'd5,  8'd0, 8'd0, 8'd0, 8'd0},
    {8'd0,  8'd0,  8'd0,  8'd0,  8'd7, 8'd1, 8'd4, 8'd2},
    {8'd30, 8'd10, 8'd20, 8'd0,  8'd2, 8'd9, 8'd0, 8'd5},
    {8'd12, 8'd0,  8'd7,  8'd3,  8'd1, 8'd1, 8'd6, 8'd6}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NCH-1:0] rails = '0;
  logic en = 1'b0;
  logic extLow = 1'b1;
  logic [NCH*DW-1:0] onD = '0, offD = '0;
  logic [NCH-1:0] g0, g1, ramp0 = '0, ramp1 = '0;
  logic rd0, rd1, drv0, drv1, line;

  int chkCnt = 0;
  int errCnt = 0;
  int riseAt [NCH];
  int fallAt [NCH];
  int rdAt, maxR;

  always #2 clk = ~clk;

  assign line = ~(extLow | drv0 | drv1);

  always @(posedge clk) begin
    ramp0 <= g0;
    ramp1 <= g1;
  end

  rail_sequencer #(.NCH(NCH), .DW(DW), .TICK_DIV(DIV), .FILT_CYC(FILT),
    .QUAL_MS(QUAL), .SETTLE_MS(SETTLE), .EN_ACTIVE_HIGH(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .railGood(rails), .enIn(en), .sysRstIn(line),
    .sysRstDrv(drv0), .rampDone(ramp0), .onDelay(onD), .offDelay(offD),
    .gateEn(g0), .resetDone(rd0));

  rail_sequencer #(.NCH(NCH), .DW(DW), .TICK_DIV(DIV), .FILT_CYC(FILT),
    .QUAL_MS(QUAL), .SETTLE_MS(SETTLE), .EN_ACTIVE_HIGH(1'b0)) u1 (
    .clk(clk), .rstN(rstN), .railGood(rails), .enIn(~en), .sysRstIn(line),
    .sysRstDrv(drv1), .rampDone(ramp1), .onDelay(onD), .offDelay(offD),
    .gateEn(g1), .resetDone(rd1));

  task automatic chk(input string req, input int act, input int exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitDone();
    for (int n = 0; n < 2000 && !rd0; n++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chkCnt++;
    errCnt++;
    $display("FAIL watchdog expired, actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R12 reset state
    chk("R12 gates after reset", g0, 0);
    chk("R12 reset-done after reset", rd0, 0);
    chk("R12 sysrst drive after reset", drv0, 0);
    rstN = 1'b1;
    @(negedge clk);
    rails = ALL;
    en = 1'b1;
    repeat (20) @(negedge clk);

    // table walk: fast start via line release, on order, settle, off order
    for (int v = 0; v < 6; v++) begin
      onD = VEC[v][63:32];
      offD = VEC[v][31:0];
      extLow = 1'b1;
      en = 1'b1;
      repeat (20) @(negedge clk);
      extLow = 1'b0;
      for (int c = 0; c < NCH; c++) riseAt[c] = -1;
      rdAt = -1;
      for (int n = 1; n <= 2000 && rdAt < 0; n++) begin
        @(negedge clk);
        for (int c = 0; c < NCH; c++) if (g0[c] && riseAt[c] < 0) riseAt[c] = n;
        if (rd0) rdAt = n;
      end
      maxR = 0;
      for (int c = 0; c < NCH; c++) begin
        chk("R3 R8 gate on cycle", riseAt[c], 1 + (int'(onD[c*DW +: DW]) + 1) * DIV);
        if (riseAt[c] > maxR) maxR = riseAt[c];
      end
      chk("R4 reset-done cycle", rdAt, maxR + 2 + SETTLE * DIV);
      chk("R9 active-low instance gates", g1, g0);
      chk("R9 active-low instance done", rd1, rd0);

      en = 1'b0;
      for (int c = 0; c < NCH; c++) fallAt[c] = -1;
      for (int n = 1; n <= 2000 && (g0 != '0 || n <= FILT + 1); n++) begin
        @(negedge clk);
        if (n == FILT) chk("R1 R6 done held inside filter", rd0, 1);
        if (n == FILT + 1) begin
          chk("R6 reset-done low first", rd0, 0);
          chk("R6 gates unchanged at done fall", g0, ALL);
        end
        for (int c = 0; c < NCH; c++) if (!g0[c] && fallAt[c] < 0) fallAt[c] = n;
      end
      for (int c = 0; c < NCH; c++)
        chk("R6 gate off cycle", fallAt[c], FILT + 1 + (int'(offD[c*DW +: DW]) + 1) * DIV);
    end

    // R2: normal qualification with line high
    onD = '0;
    offD = '0;
    repeat (5) @(negedge clk);
    en = 1'b1;
    for (int n = 1; n <= FILT + (QUAL + 1) * DIV; n++) begin
      @(negedge clk);
      if (n == FILT + (QUAL + 1) * DIV - 1) chk("R2 gates before window end", g0, 0);
      if (n == FILT + (QUAL + 1) * DIV)     chk("R2 gates after window", g0, ALL);
    end
    waitDone();
    chk("R4 running after qualified start", rd0, 1);

    // R1: short rail and enable dropouts ignored
    rails[2] = 1'b0;
    repeat (FILT - 1) @(negedge clk);
    rails = ALL;
    repeat (10) @(negedge clk);
    chk("R1 rail glitch done", rd0, 1);
    chk("R1 rail glitch gates", g0, ALL);
    chk("R1 rail glitch drive", drv0, 0);
    en = 1'b0;
    repeat (FILT - 1) @(negedge clk);
    en = 1'b1;
    repeat (10) @(negedge clk);
    chk("R1 enable glitch done", rd0, 1);
    chk("R1 enable glitch gates", g0, ALL);

    // R5 / R11: sustained rail loss
    rails[1] = 1'b0;
    for (int n = 1; n <= FILT + 1; n++) begin
      @(negedge clk);
      if (n == FILT) chk("R1 gates before filter expiry", g0, ALL);
      if (n == FILT + 1) begin
        chk("R5 gates cut on fault", g0, 0);
        chk("R5 done low on fault", rd0, 0);
        chk("R5 sysrst driven on fault", drv0, 1);
      end
    end
    repeat (20) @(negedge clk);
    chk("R11 drive held during fault", drv0, 1);
    chk("R11 line low during fault", line, 0);

    // R10 / R8: recovery needs the full window, own release ignored
    rails = ALL;
    for (int n = 1; n <= FILT + 1 + (QUAL + 1) * DIV; n++) begin
      @(negedge clk);
      if (n == FILT + 1) chk("R10 drive released", drv0, 0);
      if (n == FILT + (QUAL + 1) * DIV) chk("R8 R10 no restart before window", g0, 0);
      if (n == FILT + 1 + (QUAL + 1) * DIV) chk("R10 restart after window", g0, ALL);
    end
    waitDone();

    // R7: external pull-down kills gates
    extLow = 1'b1;
    @(negedge clk);
    chk("R7 gates off after line low", g0, 0);
    chk("R7 second instance gates off", g1, 0);
    chk("R7 done low after line low", rd0, 0);
    repeat (5) @(negedge clk);
    chk("R7 gates stay off", g0, 0);

    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

endmodule